// File: doc/BRIEF.md
# Resettable-Code Combination Lock

This block holds a secret code of `WIDTH` bits (four by default) and reports whether the value on its input vector matches it. The same input vector serves both to program the code and to present a guess. When the load strobe is high at a rising clock edge, every stage captures its input bit. When the strobe is low, every stage keeps its bit, and the comparison runs against the stored code.

Each bit stage holds one stored bit and produces an equality term, which is the XNOR of its stored bit and its input bit. These terms are combined by a ripple AND chain. The first stage, at bit 0, begins the chain with its own term. Every later stage ANDs its term with the result of the stage before it. The match flag is the output of the last stage. It is combinational, so it is valid in every cycle, including a load cycle. In a load cycle it compares against the code stored before that edge.

Each stage runs in one of two named modes, decoded from the strobe. HOLD applies while the strobe is low and keeps the bit (HOLD→HOLD). LOAD applies while the strobe is high and captures the input bit at the edge (HOLD→LOAD when the strobe rises, LOAD→HOLD when it falls). A synchronous reset overrides both modes.

Top module: `code_lock_top`

## Requirements
- R1: At a clock edge with `rst` high, the stored code becomes all zeros, so after reset `code_o` is 0 and a guess of 0 gives `match_o` = 1.
- R2: At a clock edge with `rst` low and `set_en_i` high, `code_o` takes the value of `guess_i` from that edge.
- R3: At a clock edge with `rst` and `set_en_i` both low, `code_o` keeps its value, whatever `guess_i` is.
- R4: `match_o` is 1 exactly when `guess_i` equals `code_o` on all bits, and it follows `guess_i` in the same cycle without waiting for a clock edge.
- R5: A mismatch in any single bit position clears `match_o`, including bit 0 (the stage that starts the chain) and the last bit.
- R6: During a cycle with `set_en_i` high, `match_o` compares `guess_i` with the code stored before that edge, not with the value being loaded.
- R7: `rst` takes priority over `set_en_i`: a reset edge with the strobe high still leaves `code_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| guess_i | input | WIDTH | Code to load or guess to test |
| set_en_i | input | 1 | Load strobe: high stores `guess_i` at the edge |
| match_o | output | 1 | High when `guess_i` equals the stored code |
| code_o | output | WIDTH | Stored code |

## Verification
The strobe can load a new code in the same cycle in which the match flag is reported. The bench provokes this by raising `set_en_i` with a guess that differs from the stored code, and again with a guess equal to the stored code. In each case it expects `match_o` to reflect the old code during that cycle and `code_o` to change only after the edge. A reset edge is also applied while the strobe is high, and the bench expects reset to win.

// File: rtl/lock_pkg.sv
package lock_pkg;
    typedef enum logic {
        MODE_HOLD = 1'b0,
        MODE_LOAD = 1'b1
    } stage_mode_e;
endpackage

// File: rtl/lock_mode_dec.sv
module lock_mode_dec
    import lock_pkg::*;
(
    input  logic        set_en_i,
    output stage_mode_e mode_o
);
    always_comb begin
        mode_o = set_en_i ? MODE_LOAD : MODE_HOLD;
    end
endmodule

// File: rtl/lock_stage.sv
module lock_stage
    import lock_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  stage_mode_e mode_i,
    input  logic        new_bit_i,
    output logic        stored_o,
    output logic        eq_o
);
    logic bit_q;

    // State register: reset first, then mode selects load or hold.
    always_ff @(posedge clk) begin
        if (rst) begin
            bit_q <= 1'b0;
        end else begin
            unique case (mode_i)
                MODE_LOAD: bit_q <= new_bit_i;
                MODE_HOLD: bit_q <= bit_q;
            endcase
        end
    end

    // Outputs: stored bit and its equality term against the live input.
    always_comb begin
        stored_o = bit_q;
        eq_o     = ~(bit_q ^ new_bit_i);
    end

    assert_load_R2: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_LOAD) |=> (stored_o == $past(new_bit_i)));

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MODE_HOLD) |=> $stable(stored_o));
endmodule

// File: rtl/code_lock_top.sv
module code_lock_top
    import lock_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] guess_i,
    input  logic             set_en_i,
    output logic             match_o,
    output logic [WIDTH-1:0] code_o
);
    localparam int LAST = WIDTH - 1;

    stage_mode_e      mode;
    logic [WIDTH-1:0] eq_bits;
    logic [WIDTH-1:0] carry;

    lock_mode_dec u_mode (
        .set_en_i (set_en_i),
        .mode_o   (mode)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        lock_stage u_stage (
            .clk       (clk),
            .rst       (rst),
            .mode_i    (mode),
            .new_bit_i (guess_i[i]),
            .stored_o  (code_o[i]),
            .eq_o      (eq_bits[i])
        );
        if (i == 0) begin : g_head
            // First stage has no incoming carry.
            assign carry[i] = eq_bits[i];
        end else begin : g_link
            assign carry[i] = eq_bits[i] & carry[i-1];
        end
    end

    assign match_o = carry[LAST];

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (code_o == '0));

    assert_match_R4: assert property (@(posedge clk) disable iff (rst)
        match_o == (guess_i == code_o));

    assert_reset_wins_R7: assert property (@(posedge clk)
        (rst && set_en_i) |=> (code_o == '0));

    assert_head_mismatch_R5: assert property (@(posedge clk) disable iff (rst)
        (guess_i[0] != code_o[0]) |-> !match_o);
endmodule

// File: tb/tb_code_lock_top.sv
module tb_code_lock_top;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] guess_i = '0;
    logic         set_en_i = 1'b0;
    logic         match_o;
    logic [W-1:0] code_o;

    always #4 clk = ~clk;

    code_lock_top #(.WIDTH(W)) dut (
        .clk      (clk),
        .rst      (rst),
        .guess_i  (guess_i),
        .set_en_i (set_en_i),
        .match_o  (match_o),
        .code_o   (code_o)
    );

    typedef struct {
        logic         exp_match;
        logic [W-1:0] exp_code;
        string        tag;
    } item_t;

    item_t        sb_q[$];
    int           checks = 0;
    int           errors = 0;
    logic [W-1:0] model_code = '0;
    logic [W-1:0] model_next = '0;
    bit           done = 0;

    // Driver: apply inputs after a falling edge, push the expected result.
    task automatic step(input logic [W-1:0] g, input logic s, input logic r,
                        input string tag);
        item_t it;
        @(negedge clk);
        model_code = model_next;
        guess_i  = g;
        set_en_i = s;
        rst      = r;
        #1;
        if (r) model_next = '0;
        else if (s) model_next = g;
        if (!r) begin
            it.exp_match = (g == model_code);
            it.exp_code  = model_code;
            it.tag       = tag;
            sb_q.push_back(it);
        end
    endtask

    // Monitor: compare before the next rising edge.
    initial begin
        forever begin
            item_t it;
            wait (sb_q.size() > 0);
            #1;
            it = sb_q.pop_front();
            checks++;
            if (match_o !== it.exp_match) begin
                errors++;
                $display("FAIL %s match actual=%b expected=%b", it.tag, match_o, it.exp_match);
            end
            checks++;
            if (code_o !== it.exp_code) begin
                errors++;
                $display("FAIL %s code actual=%b expected=%b", it.tag, code_o, it.exp_code);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        step(4'hF, 1'b0, 1'b1, "R1");
        step(4'h0, 1'b0, 1'b0, "R1");            // after reset: code 0, guess 0 matches
        step(4'hA, 1'b1, 1'b0, "R6");            // load cycle: compares against old 0
        step(4'hA, 1'b0, 1'b0, "R2");            // loaded value now visible
        for (int b = 0; b < W; b++)
            step(4'hA ^ (4'h1 << b), 1'b0, 1'b0, "R5");
        step(4'h3, 1'b0, 1'b0, "R3");
        step(4'h5, 1'b0, 1'b0, "R3");
        step(4'hA, 1'b1, 1'b0, "R6");            // load with guess equal to old code
        step(4'h6, 1'b1, 1'b0, "R2");
        step(4'h6, 1'b0, 1'b0, "R2");
        for (int v = 0; v < 16; v++)
            step(v[W-1:0], 1'b0, 1'b0, "R4");
        step(4'hF, 1'b1, 1'b1, "R7");            // reset wins over load
        step(4'h0, 1'b0, 1'b0, "R7");
        step(4'h9, 1'b1, 1'b0, "R2");
        step(4'h9, 1'b0, 1'b0, "R4");
        step(4'h8, 1'b0, 1'b0, "R5");
        step(4'h1, 1'b0, 1'b0, "R5");
        @(negedge clk);
        wait (sb_q.size() == 0);
        #3;
        finish_run();
    end
endmodule